// File: doc/BRIEF.md
# Dual Checksum Stripe Encoder over GF(16)

This block produces the two checksum symbols that protect one stripe of a disk array against the loss of any two drives. Every data drive supplies one 4-bit symbol of the finite field GF(2^4). The block treats the stripe as a shortened Reed-Solomon codeword whose generator polynomial has the roots 1 and alpha. Each drive reaches the checksums through a pair of fixed constants, and each product is built only from XOR gates. The contributions of all drives are combined by XOR. A drive that is switched off counts as a zero symbol. Drives can therefore be added to the array later without changing the constants of the drives already in it.

There are two ways to use the block. A start strobe encodes the whole stripe in one cycle from every enabled drive. A step strobe with a drive index and a change value folds that one drive's contribution into the checksums already held. This is the path for a small write, where only one drive's data changes and the delta is the XOR of its old and new symbol. Both operations register their result, and a valid flag pulses for one cycle after either one.

Top module: `stripe_chk_enc`

## Requirements
- R1: Symbols are 4 bits over GF(2^4) with p(x)=1+x+x^4. Bit 3 holds the coefficient of alpha^0 and bit 0 holds the coefficient of alpha^3. So 1 is 4'b1000, alpha is 4'b0100 and alpha^4 is 4'b1100.
- R2: Drive k (counting from 1, on drv_data bits [4k-1:4k-4]) sits at codeword position x^(k+1). The codeword is chk1 + chk2·x + the sum of Dk·x^(k+1). Its value at x=1 and at x=alpha is zero.
- R3: A start in cycle t loads chk1/chk2 with the full-stripe result of the inputs seen in cycle t. The result is visible after that edge, and chk_valid is high for exactly that one following cycle.
- R4: A drive whose drv_en bit is 0 contributes nothing to a start, whatever its data. With every drive disabled, a start gives chk1=chk2=0.
- R5: With D1=4'b0100, D5=4'b1100 and all other drives zero, a start gives chk1=4'b0101 and chk2=4'b1101.
- R6: A step without start, where step_idx (0 selects D1) names an enabled drive, XORs step_delta times that drive's constants into the held checksums. chk_valid pulses one cycle later.
- R7: A step whose step_idx is NUM_DRIVES or larger, or names a disabled drive, leaves chk1/chk2 unchanged and raises no chk_valid.
- R8: When start and step are high in the same cycle, only the start is performed.
- R9: In a cycle with neither start nor an accepted step, chk1/chk2 hold their values in the next cycle and chk_valid is low.
- R10: Synchronous reset clears chk1, chk2 and chk_valid, and they stay clear until the first start or accepted step.
- R11: The unit-data constants (chk1, chk2) are (alpha, alpha^4) for D1, (alpha^5, alpha^10) for D2 and (alpha^7, alpha^9) for D5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Encode the full stripe from all enabled drives |
| drv_en | input | NUM_DRIVES | Per-drive enable; a disabled drive counts as zero |
| drv_data | input | 4*NUM_DRIVES | Drive symbols, D1 in the lowest nibble |
| step | input | 1 | Fold one drive's change into the held checksums |
| step_idx | input | IDX_W | Drive index for step, 0 selects D1 |
| step_delta | input | 4 | Change symbol (old XOR new) for step |
| chk1 | output | 4 | Checksum coefficient of x^0 |
| chk2 | output | 4 | Checksum coefficient of x^1 |
| chk_valid | output | 1 | One-cycle pulse after a start or an accepted step |

## Verification
The bench builds its reference from the two syndrome equations rather than from division. This exposes a drive wired to the wrong codeword position: that fault shows up as a wrong pair on a unit-data drive or on the stated two-drive example. Random stripes mix enabled and disabled drives, so a design that ignores drv_en produces nonzero terms from masked data. Step sequences include indices past the last drive and indices of disabled drives. A design that wraps the index, or accepts those steps, alters the held checksums or pulses chk_valid. Start and step are also raised together: a design that lets the step win, or XORs the step on top of the load, returns a value different from the plain stripe encode.

// File: rtl/sce_pkg.sv
package sce_pkg;
  // R1: 4-bit symbols, bit 3 = alpha^0 coefficient, field polynomial 1+x+x^4
  localparam int SYM_W = 4;
  localparam int MAX_DRIVES = 13;
  typedef logic [SYM_W-1:0] sym_t;

  localparam sym_t SYM_ONE = 4'b1000;
  localparam sym_t SYM_ALPHA4 = 4'b1100;

  // Multiply by alpha: one XOR gate
  function automatic sym_t times_alpha(sym_t v);
    return {v[0], v[3] ^ v[0], v[2], v[1]};
  endfunction

  // Product with a constant, used while elaborating constants only
  function automatic sym_t const_mul(sym_t a, sym_t k);
    sym_t acc;
    sym_t p;
    acc = '0;
    p = a;
    for (int b = 0; b < SYM_W; b++) begin
      if (k[SYM_W-1-b]) acc = acc ^ p;
      p = times_alpha(p);
    end
    return acc;
  endfunction

  // Residue of x^pos modulo x^2 + alpha^4 x + alpha, returned as {x^1 coef, x^0 coef}
  function automatic logic [2*SYM_W-1:0] pos_residue(int pos);
    sym_t r1;
    sym_t r0;
    sym_t n1;
    r1 = '0;
    r0 = SYM_ONE;
    for (int s = 0; s < pos; s++) begin
      n1 = const_mul(r1, SYM_ALPHA4) ^ r0;
      r0 = const_mul(r1, 4'b0100);
      r1 = n1;
    end
    return {r1, r0};
  endfunction
endpackage

// File: rtl/ckenc_opsel.sv
module ckenc_opsel
  import sce_pkg::*;
#(
  parameter int NUM_DRIVES = 13,
  parameter int IDX_W = 4
) (
  input  logic                              start,
  input  logic                              step,
  input  logic [IDX_W-1:0]                  step_idx,
  input  logic [SYM_W-1:0]                  step_delta,
  input  logic [NUM_DRIVES-1:0]             drv_en,
  input  logic [NUM_DRIVES*SYM_W-1:0]       drv_data,
  output logic [NUM_DRIVES-1:0][SYM_W-1:0]  operand,
  output logic                              take_load,
  output logic                              take_step
);
  logic [NUM_DRIVES-1:0] hit;

  // R8: start overrides step; R6/R7: only an enabled, in-range drive accepts a step
  for (genvar i = 0; i < NUM_DRIVES; i++) begin : g_drv
    assign hit[i] = step && drv_en[i] && (step_idx == IDX_W'(i));
    always_comb begin
      if (start)
        operand[i] = drv_en[i] ? drv_data[i*SYM_W +: SYM_W] : '0;
      else if (hit[i])
        operand[i] = step_delta;
      else
        operand[i] = '0;
    end
  end

  assign take_load = start;
  assign take_step = !start && (|hit);
endmodule

// File: rtl/ckenc_term.sv
module ckenc_term
  import sce_pkg::*;
#(
  parameter int POS = 2
) (
  input  logic [SYM_W-1:0] din,
  output logic [SYM_W-1:0] t1,
  output logic [SYM_W-1:0] t2
);
  // R2/R11: constant pair of this codeword position, fixed at elaboration
  localparam logic [2*SYM_W-1:0] RES = pos_residue(POS);
  localparam sym_t K1 = RES[SYM_W-1:0];
  localparam sym_t K2 = RES[2*SYM_W-1:SYM_W];

  // din*alpha^k chain shared by both checksum networks
  logic [SYM_W-1:0][SYM_W-1:0] chain;
  logic [SYM_W-1:0][SYM_W-1:0] sel1;
  logic [SYM_W-1:0][SYM_W-1:0] sel2;

  assign chain[0] = din;
  for (genvar k = 1; k < SYM_W; k++) begin : g_chain
    assign chain[k] = times_alpha(chain[k-1]);
  end

  for (genvar k = 0; k < SYM_W; k++) begin : g_sel
    if (K1[SYM_W-1-k]) begin : g_on1
      assign sel1[k] = chain[k];
    end else begin : g_off1
      assign sel1[k] = '0;
    end
    if (K2[SYM_W-1-k]) begin : g_on2
      assign sel2[k] = chain[k];
    end else begin : g_off2
      assign sel2[k] = '0;
    end
  end

  always_comb begin
    t1 = '0;
    t2 = '0;
    for (int k = 0; k < SYM_W; k++) begin
      t1 = t1 ^ sel1[k];
      t2 = t2 ^ sel2[k];
    end
  end
endmodule

// File: rtl/ckenc_xor_tree.sv
module ckenc_xor_tree
  import sce_pkg::*;
#(
  parameter int NUM_IN = 13
) (
  input  logic [NUM_IN-1:0][SYM_W-1:0] terms,
  output logic [SYM_W-1:0]             sum
);
  always_comb begin
    sum = '0;
    for (int i = 0; i < NUM_IN; i++) sum = sum ^ terms[i];
  end
endmodule

// File: rtl/stripe_chk_enc.sv
module stripe_chk_enc
  import sce_pkg::*;
#(
  parameter int NUM_DRIVES = 13,
  localparam int IDX_W = $clog2(NUM_DRIVES + 1)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        start,
  input  logic [NUM_DRIVES-1:0]       drv_en,
  input  logic [NUM_DRIVES*4-1:0]     drv_data,
  input  logic                        step,
  input  logic [IDX_W-1:0]            step_idx,
  input  logic [3:0]                  step_delta,
  output logic [3:0]                  chk1,
  output logic [3:0]                  chk2,
  output logic                        chk_valid
);
  logic [NUM_DRIVES-1:0][SYM_W-1:0] operand;
  logic [NUM_DRIVES-1:0][SYM_W-1:0] c1_terms;
  logic [NUM_DRIVES-1:0][SYM_W-1:0] c2_terms;
  logic [SYM_W-1:0] sum1;
  logic [SYM_W-1:0] sum2;
  logic take_load;
  logic take_step;

  ckenc_opsel #(.NUM_DRIVES(NUM_DRIVES), .IDX_W(IDX_W)) u_opsel (
    .start(start), .step(step), .step_idx(step_idx), .step_delta(step_delta),
    .drv_en(drv_en), .drv_data(drv_data), .operand(operand),
    .take_load(take_load), .take_step(take_step)
  );

  // R2: drive i (0-based) sits at x^(i+2)
  for (genvar i = 0; i < NUM_DRIVES; i++) begin : g_term
    ckenc_term #(.POS(i + 2)) u_term (
      .din(operand[i]), .t1(c1_terms[i]), .t2(c2_terms[i])
    );
  end

  ckenc_xor_tree #(.NUM_IN(NUM_DRIVES)) u_sum1 (.terms(c1_terms), .sum(sum1));
  ckenc_xor_tree #(.NUM_IN(NUM_DRIVES)) u_sum2 (.terms(c2_terms), .sum(sum2));

  // R3/R6/R9/R10: registered checksums and one-cycle valid
  always_ff @(posedge clk) begin
    if (rst) begin
      chk1 <= '0;
      chk2 <= '0;
      chk_valid <= 1'b0;
    end else begin
      chk_valid <= take_load | take_step;
      if (take_load) begin
        chk1 <= sum1;
        chk2 <= sum2;
      end else if (take_step) begin
        chk1 <= chk1 ^ sum1;
        chk2 <= chk2 ^ sum2;
      end
    end
  end
endmodule

// File: rtl/stripe_chk_enc_props.sv
module stripe_chk_enc_props #(
  parameter int NUM_DRIVES = 13,
  parameter int IDX_W = 4
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  start,
  input logic [NUM_DRIVES-1:0] drv_en,
  input logic                  step,
  input logic [IDX_W-1:0]      step_idx,
  input logic [3:0]            step_delta,
  input logic [3:0]            chk1,
  input logic [3:0]            chk2,
  input logic                  chk_valid
);
  logic step_ok;
  always_comb begin
    step_ok = 1'b0;
    for (int i = 0; i < NUM_DRIVES; i++)
      if (step && !start && drv_en[i] && step_idx == IDX_W'(i)) step_ok = 1'b1;
  end

  // R10
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (chk1 == 4'b0 && chk2 == 4'b0 && !chk_valid));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!start && !step) |=> ($stable(chk1) && $stable(chk2) && !chk_valid));

  // R7
  step_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (step && !start && !step_ok) |=> ($stable(chk1) && $stable(chk2) && !chk_valid));

  // R3
  valid_cause_chk: assert property (@(posedge clk) disable iff (rst)
    chk_valid |-> $past(start || step_ok));

  // R4
  all_off_chk: assert property (@(posedge clk) disable iff (rst)
    (start && drv_en == '0) |=> (chk1 == 4'b0 && chk2 == 4'b0 && chk_valid));

  // R6
  zero_delta_chk: assert property (@(posedge clk) disable iff (rst)
    (step_ok && step_delta == 4'b0) |=> ($stable(chk1) && $stable(chk2) && chk_valid));
endmodule

bind stripe_chk_enc stripe_chk_enc_props #(.NUM_DRIVES(NUM_DRIVES), .IDX_W(IDX_W)) u_props (
  .clk(clk), .rst(rst), .start(start), .drv_en(drv_en), .step(step),
  .step_idx(step_idx), .step_delta(step_delta), .chk1(chk1), .chk2(chk2),
  .chk_valid(chk_valid)
);

// File: tb/stripe_chk_enc_test.sv
`timescale 1ns/1ps
module stripe_chk_enc_test;
  localparam int N = 13;
  localparam int IW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic step = 1'b0;
  logic [N-1:0] en = '0;
  logic [N*4-1:0] data = '0;
  logic [IW-1:0] idx = '0;
  logic [3:0] delta = '0;
  logic [3:0] chk1, chk2;
  logic chk_valid;

  int checks = 0;
  int fails = 0;
  logic [3:0] exp_t [15];
  int log_t [16];
  logic [7:0] held;

  always #2.5 clk = ~clk;

  stripe_chk_enc #(.NUM_DRIVES(N)) uut (
    .clk(clk), .rst(rst), .start(start), .drv_en(en), .drv_data(data),
    .step(step), .step_idx(idx), .step_delta(delta),
    .chk1(chk1), .chk2(chk2), .chk_valid(chk_valid)
  );

  function automatic logic [3:0] gmul(logic [3:0] a, logic [3:0] b);
    if (a == 0 || b == 0) return 4'b0;
    return exp_t[(log_t[a] + log_t[b]) % 15];
  endfunction

  // Reference from the syndrome equations: c(1)=0 and c(alpha)=0
  function automatic logic [7:0] ref_chk(logic [N*4-1:0] d, logic [N-1:0] e);
    logic [3:0] s0, s1, sy, c1, c2, v;
    s0 = 0; s1 = 0;
    for (int i = 0; i < N; i++) begin
      v = e[i] ? d[i*4 +: 4] : 4'b0;
      s0 ^= v;
      s1 ^= gmul(v, exp_t[(i + 2) % 15]);
    end
    sy = s0 ^ s1;
    c2 = (sy == 0) ? 4'b0 : exp_t[(log_t[sy] + 11) % 15];
    c1 = s0 ^ c2;
    return {c2, c1};
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic do_load(logic [N*4-1:0] d, logic [N-1:0] e, string req);
    data = d; en = e; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    held = ref_chk(d, e);
    check(req, {chk2, chk1}, held);
    check("R3 valid high", {7'b0, chk_valid}, 8'd1);
  endtask

  task automatic do_step(int i, logic [3:0] dl);
    logic [N*4-1:0] one;
    logic ok;
    idx = IW'(i); delta = dl; step = 1'b1;
    ok = (i < N) && en[i];
    @(negedge clk);
    step = 1'b0;
    if (ok) begin
      one = '0;
      one[i*4 +: 4] = dl;
      held = held ^ ref_chk(one, '1);
      check("R6 step value", {chk2, chk1}, held);
      check("R6 step valid", {7'b0, chk_valid}, 8'd1);
    end else begin
      check("R7 ignored step value", {chk2, chk1}, held);
      check("R7 ignored step valid", {7'b0, chk_valid}, 8'd0);
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int c;
    logic [N*4-1:0] d;
    void'($urandom(32'd4242));
    // Field tables: integer bit k = coefficient of alpha^k, then mirrored to the port order
    c = 1;
    for (int e = 0; e < 15; e++) begin
      exp_t[e] = {c[0], c[1], c[2], c[3]};
      log_t[{c[0], c[1], c[2], c[3]}] = e;
      c = c << 1;
      if (c & 16) c = c ^ 'b10011;
    end

    // R10 reset state
    repeat (3) @(negedge clk);
    check("R10 reset value", {chk2, chk1, 3'b0, chk_valid}, 8'h00);
    rst = 1'b0;
    @(negedge clk);
    check("R10 after release", {chk2, chk1, 3'b0, chk_valid}, 8'h00);
    held = 0;

    // R5 and R1: stated example
    d = '0; d[3:0] = 4'b0100; d[19:16] = 4'b1100;
    do_load(d, '1, "R5 R1 example");
    check("R5 exact pair", {chk2, chk1}, {4'b1101, 4'b0101});
    @(negedge clk);
    check("R3 valid one cycle", {7'b0, chk_valid}, 8'd0);

    // R2 and R11: unit data on every drive
    for (int i = 0; i < N; i++) begin
      d = '0; d[i*4 +: 4] = 4'b1000;
      do_load(d, '1, "R2 unit drive");
      if (i == 0) check("R11 D1 constants", {chk2, chk1}, {4'b1100, 4'b0100});
      if (i == 1) check("R11 D2 constants", {chk2, chk1}, {4'b1110, 4'b0110});
      if (i == 4) check("R11 D5 constants", {chk2, chk1}, {4'b0101, 4'b1101});
    end

    // R4: everything disabled
    for (int i = 0; i < N; i++) d[i*4 +: 4] = 4'($urandom | 1);
    do_load(d, '0, "R4 all disabled");
    check("R4 zero pair", {chk2, chk1}, 8'h00);

    // R3/R4: random stripes with random enables
    for (int r = 0; r < 40; r++) begin
      for (int i = 0; i < N; i++) d[i*4 +: 4] = 4'($urandom);
      do_load(d, N'($urandom), "R3 R4 random stripe");
    end

    // R6/R7: steps, including out-of-range and disabled indices
    for (int i = 0; i < N; i++) d[i*4 +: 4] = 4'($urandom);
    do_load(d, 13'b1011011101101, "R3 base stripe");
    for (int r = 0; r < 80; r++) do_step($urandom % 16, 4'($urandom));
    do_step(13, 4'b1111);
    do_step(15, 4'b0110);
    do_step(1, 4'b1010);
    do_step(0, 4'b0000);

    // R8: start and step together
    for (int i = 0; i < N; i++) d[i*4 +: 4] = 4'($urandom);
    idx = 0; delta = 4'b1111; step = 1'b1;
    do_load(d, '1, "R8 start wins");
    step = 1'b0;

    // R9: idle holds
    for (int r = 0; r < 5; r++) begin
      @(negedge clk);
      check("R9 hold value", {chk2, chk1}, held);
      check("R9 valid low", {7'b0, chk_valid}, 8'd0);
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule